// File: doc/BRIEF.md
# Register-Driven Block Copy Engine

This block moves a run of bytes from one place in a 24-bit memory space to another. It takes no operands. Four user-visible 16-bit registers hold every parameter. The bank register A carries both bank bytes: the source bank in its low half and the destination bank in its high half. X and Y hold the 16-bit offsets of the next source byte and the next destination byte. Z holds the number of bytes still to move, minus one.

Once started, the engine spends a fixed slot on each byte. The slot has overhead cycles (two by default), one read cycle and one write cycle on a simple synchronous bus. After each write it steps X, Y and Z in place. Because all progress lives in those registers, a pending interrupt can stop the run between bytes. A later start resumes the copy exactly where it stopped. A single-cycle done pulse marks the end of the whole block.

Top module: `blkcopy_engine`

## Requirements
- R1: The read address is {A[7:0], X[15:0]}: bits 23:16 come from the low byte of A and bits 15:0 from X.
- R2: The write address is {A[15:8], Y[15:0]}: bits 23:16 come from the high byte of A and bits 15:0 from Y.
- R3: A run moves Z+1 bytes and ends after the byte moved while Z was $0000. Z is then $FFFF, busy drops, and done is high for exactly one cycle. For example, A=$FF00, X=$8000, Y=$1000, Z=$01FF moves $008000..$0081FF to $FF1000..$FF11FF.
- R4: Every byte takes four cycles counted from the start edge or from the previous byte's write cycle: two overhead cycles, one cycle with mem_rd high, then one cycle with mem_wr high. The written data equals the byte returned during the read cycle.
- R5: After each write, X and Y each rise by one and wrap within 16 bits; A is never changed, so no carry reaches the bank byte. Z falls by one.
- R6: irq_pend is looked at only in the last cycle of a byte's write. If it is high there and the byte was not the last, the engine stops with the stepped registers and raises paused. A later start clears paused and continues. On the last byte, done takes priority and paused stays low.
- R7: While busy, start and ld_en have no effect. A load writes A, X, Y and Z only while the engine is idle.
- R8: After reset the engine is idle: busy, done, paused, mem_rd and mem_wr are low, and A, X, Y and Z read $0000.
- R9: mem_rd and mem_wr are never high together, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume a copy; used only when idle |
| irq_pend | input | 1 | Interrupt waiting; sampled at the end of each write |
| ld_en | input | 1 | Load the four registers; used only when idle |
| ld_a | input | 16 | Bank pair to load (low byte = source bank, high byte = destination bank) |
| ld_x | input | 16 | Source offset to load |
| ld_y | input | 16 | Destination offset to load |
| ld_z | input | 16 | Byte count minus one to load |
| a_o | output | 16 | Current bank pair |
| x_o | output | 16 | Current source offset |
| y_o | output | 16 | Current destination offset |
| z_o | output | 16 | Current remaining count minus one |
| mem_addr | output | 24 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_rd |
| busy | output | 1 | A copy is running |
| done | output | 1 | One-cycle pulse when a copy completes |
| paused | output | 1 | Copy stopped between bytes on an interrupt |

## Verification
A slot counter that drifts shows up on the very next byte. The read or write strobe lands in the wrong cycle, which the bench checks against its own four-cycle schedule. A bad offset or bank step shows as a wrong address or wrong data on the following strobe, one slot later at most. A wrong end-of-count or interrupt decision shows in the cycle after the final write, as a missing or extra done or paused flag and wrong register values on a_o through z_o.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
   typedef enum logic [0:0] {
      RS_IDLE = 1'b0,
      RS_RUN  = 1'b1
   } run_state_t;
endpackage

// File: rtl/blkcopy_addr.sv
module blkcopy_addr #(
   parameter int OFS_W  = 16,
   parameter int BANK_W = 8
) (
   input  logic [2*BANK_W-1:0]       bank_pair,
   input  logic [OFS_W-1:0]          src_ofs,
   input  logic [OFS_W-1:0]          dst_ofs,
   output logic [BANK_W+OFS_W-1:0]   src_addr,
   output logic [BANK_W+OFS_W-1:0]   dst_addr
);
   // Low half selects the source bank, high half the destination bank.
   assign src_addr = {bank_pair[BANK_W-1:0],          src_ofs};
   assign dst_addr = {bank_pair[2*BANK_W-1:BANK_W],   dst_ofs};
endmodule

// File: rtl/blkcopy_regs.sv
module blkcopy_regs #(
   parameter int OFS_W  = 16,
   parameter int BANK_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [2*BANK_W-1:0]  ld_a,
   input  logic [OFS_W-1:0]     ld_x,
   input  logic [OFS_W-1:0]     ld_y,
   input  logic [OFS_W-1:0]     ld_z,
   input  logic                 step,
   output logic [2*BANK_W-1:0]  a_q,
   output logic [OFS_W-1:0]     x_q,
   output logic [OFS_W-1:0]     y_q,
   output logic [OFS_W-1:0]     z_q,
   output logic                 last
);
   localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         x_q <= '0;
         y_q <= '0;
         z_q <= '0;
      end else if (load) begin
         a_q <= ld_a;
         x_q <= ld_x;
         y_q <= ld_y;
         z_q <= ld_z;
      end else if (step) begin
         x_q <= x_q + ONE;
         y_q <= y_q + ONE;
         z_q <= z_q - ONE;
      end
   end

   assign last = (z_q == '0);
endmodule

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
   import blkcopy_pkg::*;
#(
   parameter int OVH_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic irq_pend,
   input  logic last,
   output logic busy,
   output logic rd_phase,
   output logic step,
   output logic done,
   output logic paused
);
   localparam int SLOT = OVH_CYC + 2;
   localparam int CW   = (SLOT > 2) ? $clog2(SLOT) : 1;
   localparam logic [CW-1:0] PH_RD = CW'(OVH_CYC);
   localparam logic [CW-1:0] PH_WR = CW'(SLOT - 1);

   run_state_t    st;
   logic [CW-1:0] ph;
   logic          in_ovh;

   generate
      if (OVH_CYC > 0) begin : g_ovh
         assign in_ovh = (ph < PH_RD);
      end else begin : g_no_ovh
         assign in_ovh = 1'b0;
      end
   endgenerate

   assign busy     = (st == RS_RUN);
   assign rd_phase = busy && !in_ovh && (ph == PH_RD);
   assign step     = busy && (ph == PH_WR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RS_IDLE;
         ph     <= '0;
         done   <= 1'b0;
         paused <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == RS_IDLE) begin
            if (start) begin
               st     <= RS_RUN;
               ph     <= '0;
               paused <= 1'b0;
            end
         end else if (ph == PH_WR) begin
            ph <= '0;
            if (last) begin
               st   <= RS_IDLE;
               done <= 1'b1;
            end else if (irq_pend) begin
               st     <= RS_IDLE;
               paused <= 1'b1;
            end
         end else begin
            ph <= ph + CW'(1);
         end
      end
   end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
   parameter int OFS_W   = 16,
   parameter int BANK_W  = 8,
   parameter int DATA_W  = 8,
   parameter int OVH_CYC = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      irq_pend,
   input  logic                      ld_en,
   input  logic [2*BANK_W-1:0]       ld_a,
   input  logic [OFS_W-1:0]          ld_x,
   input  logic [OFS_W-1:0]          ld_y,
   input  logic [OFS_W-1:0]          ld_z,
   output logic [2*BANK_W-1:0]       a_o,
   output logic [OFS_W-1:0]          x_o,
   output logic [OFS_W-1:0]          y_o,
   output logic [OFS_W-1:0]          z_o,
   output logic [BANK_W+OFS_W-1:0]   mem_addr,
   output logic                      mem_rd,
   output logic                      mem_wr,
   output logic [DATA_W-1:0]         mem_wdata,
   input  logic [DATA_W-1:0]         mem_rdata,
   output logic                      busy,
   output logic                      done,
   output logic                      paused
);
   generate
      if (OFS_W < 2)   begin : g_bad_ofs  $error("OFS_W must be at least 2");   end
      if (BANK_W < 1)  begin : g_bad_bank $error("BANK_W must be at least 1");  end
      if (DATA_W < 1)  begin : g_bad_data $error("DATA_W must be at least 1");  end
      if (OVH_CYC < 0) begin : g_bad_ovh  $error("OVH_CYC must not be negative"); end
   endgenerate

   localparam int ADDR_W = BANK_W + OFS_W;

   logic              last, step, rd_phase;
   logic [ADDR_W-1:0] src_addr, dst_addr;
   logic [DATA_W-1:0] hold_q;

   blkcopy_seq #(.OVH_CYC(OVH_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .irq_pend(irq_pend),
      .last(last), .busy(busy), .rd_phase(rd_phase), .step(step),
      .done(done), .paused(paused)
   );

   blkcopy_regs #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .load(ld_en && !busy),
      .ld_a(ld_a), .ld_x(ld_x), .ld_y(ld_y), .ld_z(ld_z),
      .step(step), .a_q(a_o), .x_q(x_o), .y_q(y_o), .z_q(z_o),
      .last(last)
   );

   blkcopy_addr #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_addr (
      .bank_pair(a_o), .src_ofs(x_o), .dst_ofs(y_o),
      .src_addr(src_addr), .dst_addr(dst_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        hold_q <= '0;
      else if (rd_phase) hold_q <= mem_rdata;
   end

   assign mem_rd    = rd_phase;
   assign mem_wr    = step;
   assign mem_addr  = step ? dst_addr : src_addr;
   assign mem_wdata = hold_q;
endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk #(
   parameter int OFS_W  = 16,
   parameter int BANK_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mem_rd,
   input logic                 mem_wr,
   input logic                 busy,
   input logic                 done,
   input logic                 paused,
   input logic [2*BANK_W-1:0]  a_o,
   input logic [OFS_W-1:0]     x_o,
   input logic [OFS_W-1:0]     z_o
);
   AST_RW_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_rd && !mem_wr)); // R9
   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
   AST_DONE_WRAP:  assert property (@(posedge clk) disable iff (!rst_n) done |-> (z_o == '1)); // R3
   AST_Z_STEP:     assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> (z_o == OFS_W'($past(z_o) - 1'b1))); // R5
   AST_X_WRAP:     assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> (x_o == OFS_W'($past(x_o) + 1'b1))); // R5
   AST_BANK_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(a_o)); // R5
   AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) paused |-> !busy); // R6
endmodule

bind blkcopy_engine blkcopy_chk #(.OFS_W(OFS_W), .BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .busy(busy), .done(done), .paused(paused),
   .a_o(a_o), .x_o(x_o), .z_o(z_o)
);

// File: tb/sim_blkcopy_engine.sv
module sim_blkcopy_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, irq_pend = 1'b0, ld_en = 1'b0;
   logic [15:0] ld_a = '0, ld_x = '0, ld_y = '0, ld_z = '0;
   logic [15:0] a_o, x_o, y_o, z_o;
   logic [23:0] mem_addr;
   logic        mem_rd, mem_wr, busy, done, paused;
   logic [7:0]  mem_wdata, mem_rdata;

   int n_chk = 0, n_bad = 0;
   logic [15:0] ea, ex, ey, ez;

   always #4 clk = ~clk;

   function automatic logic [7:0] pat(input logic [23:0] ad);
      return ad[7:0] ^ {ad[14:8], ad[15]} ^ ad[23:16] ^ 8'h5A;
   endfunction

   assign mem_rdata = pat(mem_addr);

   blkcopy_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .irq_pend(irq_pend),
      .ld_en(ld_en), .ld_a(ld_a), .ld_x(ld_x), .ld_y(ld_y), .ld_z(ld_z),
      .a_o(a_o), .x_o(x_o), .y_o(y_o), .z_o(z_o),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .paused(paused)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [15:0] a, x, y, z);
      @(negedge clk);
      ld_en = 1'b1; ld_a = a; ld_x = x; ld_y = y; ld_z = z;
      @(negedge clk);
      ld_en = 1'b0;
      ea = a; ex = x; ey = y; ez = z;
      chk({a_o, x_o, y_o, z_o} == {a, x, y, z}, "R7 load while idle", {a_o, x_o, y_o, z_o}, {a, x, y, z});
   endtask

   // Runs from the current register image; irq_at = byte number after which irq_pend is high.
   task automatic run(input int irq_at, input bit poke);
      int  cyc = 1;
      int  k = 0;
      bit  was_last = 0;
      int  limit = 4 * (int'(ez) + 1) + 8;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      forever begin
         if (poke && cyc == 2) begin
            start = 1'b1; ld_en = 1'b1;
            ld_a = ~ea; ld_x = 16'h1234; ld_y = 16'h4321; ld_z = 16'h0007;
         end
         if (cyc == 3) begin start = 1'b0; ld_en = 1'b0; end
         if (mem_rd) begin
            chk(cyc == 4 * k + 3, "R4 read cycle", cyc, 4 * k + 3);
            chk(mem_addr == {ea[7:0], ex}, "R1 read address", mem_addr, {ea[7:0], ex});
         end
         if (mem_wr) begin
            chk(cyc == 4 * k + 4, "R4 write cycle", cyc, 4 * k + 4);
            chk(mem_addr == {ea[15:8], ey}, "R2 write address", mem_addr, {ea[15:8], ey});
            chk(mem_wdata == pat({ea[7:0], ex}), "R4 write data", mem_wdata, pat({ea[7:0], ex}));
            k++;
            was_last = (ez == 16'h0000);
            ex = ex + 16'd1; ey = ey + 16'd1; ez = ez - 16'd1;
            irq_pend = (k == irq_at);
         end
         if (!busy) break;
         if (cyc > limit) begin
            chk(1'b0, "R3 run length", cyc, limit);
            break;
         end
         @(negedge clk);
         cyc++;
      end
      irq_pend = 1'b0;
      if (was_last) begin
         chk(done && !paused, "R3 done at end", {done, paused}, 2'b10);
         chk(z_o == 16'hFFFF, "R3 count wraps", z_o, 16'hFFFF);
      end else begin
         chk(paused && !done, "R6 pause on interrupt", {done, paused}, 2'b01);
      end
      chk({a_o, x_o, y_o, z_o} == {ea, ex, ey, ez}, "R5 registers after run", {a_o, x_o, y_o, z_o}, {ea, ex, ey, ez});
      @(negedge clk);
      chk(!done, "R3 done single cycle", done, 0);
      chk(!mem_rd && !mem_wr, "R9 idle strobes", {mem_rd, mem_wr}, 0);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      chk({busy, done, paused, mem_rd, mem_wr} == 5'b0, "R8 reset flags", {busy, done, paused, mem_rd, mem_wr}, 0);
      chk({a_o, x_o, y_o, z_o} == 64'h0, "R8 reset registers", {a_o, x_o, y_o, z_o}, 0);
      rst_n = 1'b1;

      // R3 worked example: 512 bytes
      load(16'hFF00, 16'h8000, 16'h1000, 16'h01FF);
      run(0, 0);
      // R3 single byte
      load(16'h1234, 16'h0042, 16'h0099, 16'h0000);
      run(0, 0);
      // R5 offset wrap without bank carry
      load(16'h0A05, 16'hFFFE, 16'hFFFF, 16'h0003);
      run(0, 0);
      // R7 start and load while busy are ignored
      load(16'h3377, 16'h2000, 16'h3000, 16'h0004);
      run(0, 1);
      // R6 pause after byte 2, then resume
      load(16'h4455, 16'h0100, 16'h0200, 16'h0005);
      run(2, 0);
      run(0, 0);
      // R6 interrupt on the last byte: done wins
      load(16'h6677, 16'h0010, 16'h0020, 16'h0002);
      run(3, 0);

      for (int i = 0; i < 25; i++) begin
         logic [15:0] a, x, y, z;
         a = 16'($urandom);
         x = ($urandom % 2 == 0) ? 16'hFFF8 + 16'($urandom_range(0, 7)) : 16'($urandom);
         y = ($urandom % 2 == 0) ? 16'hFFFA + 16'($urandom_range(0, 5)) : 16'($urandom);
         z = 16'($urandom_range(0, 12));
         load(a, x, y, z);
         run($urandom_range(1, 16), i % 5 == 0);
         if (paused) run(0, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule